// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test port of a chip. It holds the sixteen-state test-port state machine, which advances on the rising edge of the test clock under control of the mode-select input. It also holds a five-bit instruction register, a one-bit pass-through register and a 32-bit identification register. Serial data enters on the data input. The block routes the serial output from the instruction register while an instruction is being shifted, and from whichever data register the active instruction selects while data is being shifted.

The boundary register of the chip sits outside this block. The block drives it through decoded strobes: capture, shift and update, taken from the data-side states. It also supplies a boundary-select flag and an external-test flag, and it takes the boundary register's serial output back in. An active-low asynchronous reset input returns the port to its reset state. The test clock may be stopped high or low without loss of state.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The state machine follows the standard test-port transitions on each rising test-clock edge: a mode-select value of 1 held for five edges reaches Test-Logic-Reset from any state. `dr_capture`, `dr_shift` and `dr_update` are high exactly while the state is Capture-DR, Shift-DR and Update-DR respectively.
- R2: Driving `trst_n` low at once forces Test-Logic-Reset, makes the identification code the active instruction and deasserts `tdo_oe` and `extest_on`, without any clock edge.
- R3: In Capture-IR the instruction shift stage loads 5'b00001. The bits shifted out least significant first therefore begin 1, 0, 0, 0, 0.
- R4: A newly shifted instruction takes effect only at the falling test-clock edge in Update-IR. Before that the decoded flags keep their old values.
- R5: Instruction decode: 5'b00000 is external test (`bsr_sel`=1, `extest_on`=1); 5'b00010 is sample/preload (`bsr_sel`=1, `extest_on`=0); 5'b00001 selects the identification register; 5'b11111 and every unlisted code select the pass-through register (`bsr_sel`=0, `extest_on`=0).
- R6: The identification register loads in Capture-DR while the identification instruction is active. Its layout is bits [31:28] the version parameter, [27:12] 16'h6410, [11:1] 11'h020, and bit 0 = 1. It shifts out least significant bit first.
- R7: The pass-through register captures 0 in Capture-DR. In Shift-DR it delays the serial input by one bit.
- R8: `tdo` and `tdo_oe` change only on the falling test-clock edge. `tdo_oe` is 1 only while the state is Shift-IR or Shift-DR; otherwise the pad is left high-impedance.
- R9: While the boundary register is selected, `tdo` in Shift-DR carries `bsr_so` as sampled at each falling edge.
- R10: Entering Test-Logic-Reset through the mode-select input makes the identification code the active instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in |
| bsr_so | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_oe | output | 1 | Output enable for the serial-out pad |
| dr_capture | output | 1 | High in Capture-DR |
| dr_shift | output | 1 | High in Shift-DR |
| dr_update | output | 1 | High in Update-DR |
| extest_on | output | 1 | External-test instruction is active |
| bsr_sel | output | 1 | Boundary register is the selected data register |

## Verification
A wrong state in the controller shows on the three data strobes and on `tdo_oe` within the same test-clock cycle, because they decode the state directly. A corrupted instruction shows on `extest_on` and `bsr_sel` at the falling edge of Update-IR, and on the serial output during the next data scan. A fault in the capture values or in the shift paths appears only on `tdo` during the following shift, one bit per cycle. The reference model therefore compares every output on every cycle, so a divergence is reported at the first cycle where it becomes visible.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;
  localparam int IR_W = 5;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {SEL_BYPASS, SEL_ID, SEL_BOUNDARY} dr_sel_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 5'b00000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 5'b00001;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 5'b00010;
  localparam logic [IR_W-1:0] IR_CAPTURE = 5'b00001;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      default:   nxt = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= TS_RESET;
    else         state <= nxt;
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_so,
  output dr_sel_e    sel,
  output logic       extest
);
  logic [IR_W-1:0] sr_q;
  logic [IR_W-1:0] ir_q;

  // shift stage: rising edge
  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) sr_q <= IR_CAPTURE;
    else if (state == TS_CAP_IR) sr_q <= IR_CAPTURE;
    else if (state == TS_SH_IR)  sr_q <= {tdi, sr_q[IR_W-1:1]};

  // update stage: falling edge only
  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) ir_q <= OP_IDCODE;
    else if (state == TS_RESET)  ir_q <= OP_IDCODE;
    else if (state == TS_UPD_IR) ir_q <= sr_q;

  assign ir_so = sr_q[0];

  always_comb begin
    sel    = SEL_BYPASS;
    extest = 1'b0;
    case (ir_q)
      OP_EXTEST: begin sel = SEL_BOUNDARY; extest = 1'b1; end
      OP_SAMPLE: sel = SEL_BOUNDARY;
      OP_IDCODE: sel = SEL_ID;
      default:   sel = SEL_BYPASS;
    endcase
  end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import jtag_tap_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_WORD = 32'h1
) (
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state,
  input  dr_sel_e    sel,
  input  logic       tdi,
  input  logic       bsr_so,
  output logic       dr_so
);
  logic            byp_q;
  logic [ID_W-1:0] id_q;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_q  <= ID_WORD;
    end else begin
      case (state)
        TS_CAP_DR: begin
          byp_q <= 1'b0;
          if (sel == SEL_ID) id_q <= ID_WORD;
        end
        TS_SH_DR: begin
          byp_q <= tdi;
          if (sel == SEL_ID) id_q <= {tdi, id_q[ID_W-1:1]};
        end
        default: ;
      endcase
    end

  always_comb
    case (sel)
      SEL_ID:       dr_so = id_q[0];
      SEL_BOUNDARY: dr_so = bsr_so;
      default:      dr_so = byp_q;
    endcase
endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h3,
  parameter logic [15:0] ID_PART    = 16'h6410,
  parameter logic [10:0] ID_MAKER   = 11'h020
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_so,
  output logic tdo,
  output logic tdo_oe,
  output logic dr_capture,
  output logic dr_shift,
  output logic dr_update,
  output logic extest_on,
  output logic bsr_sel
);
  localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

  tap_state_e state;
  dr_sel_e    sel;
  logic       ir_so, dr_so, extest;
  logic       tdo_q, oe_q;

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  tap_ir u_ir (.tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
               .ir_so(ir_so), .sel(sel), .extest(extest));

  tap_dr #(.ID_WORD(ID_WORD)) u_dr (.tck(tck), .trst_n(trst_n), .state(state),
               .sel(sel), .tdi(tdi), .bsr_so(bsr_so), .dr_so(dr_so));

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= (state == TS_SH_IR) || (state == TS_SH_DR);
      tdo_q <= (state == TS_SH_IR) ? ir_so : dr_so;
    end

  assign tdo        = tdo_q;
  assign tdo_oe     = oe_q;
  assign dr_capture = (state == TS_CAP_DR);
  assign dr_shift   = (state == TS_SH_DR);
  assign dr_update  = (state == TS_UPD_DR);
  assign extest_on  = extest;
  assign bsr_sel    = (sel == SEL_BOUNDARY);
endmodule

// File: rtl/jtag_tap_ctrl_chk.sv
module jtag_tap_ctrl_chk
  import jtag_tap_pkg::*;
(
  input logic       tck,
  input logic       trst_n,
  input logic       tms,
  input tap_state_e state,
  input logic       tdo_oe,
  input logic       dr_capture,
  input logic       dr_shift,
  input logic       dr_update,
  input logic       extest_on,
  input logic       bsr_sel
);
  a_r2_reset_quiet: assert property (@(posedge tck)
    !trst_n |-> (!tdo_oe && !extest_on));

  a_r1_capture_leaves: assert property (@(posedge tck) disable iff (!trst_n)
    dr_capture |=> (dr_shift || state == TS_EX1_DR));

  a_r1_reset_holds: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_RESET && tms) |=> (state == TS_RESET));

  a_r1_strobes_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({dr_capture, dr_shift, dr_update}));

  a_r8_oe_only_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == TS_SH_IR || state == TS_SH_DR));

  a_r4_decode_held: assert property (@(negedge tck) disable iff (!trst_n)
    (state != TS_UPD_IR && state != TS_RESET) |=> ($stable(extest_on) && $stable(bsr_sel)));

  a_r5_extest_is_boundary: assert property (@(posedge tck) disable iff (!trst_n)
    extest_on |-> bsr_sel);
endmodule

bind jtag_tap_ctrl jtag_tap_ctrl_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .tdo_oe(tdo_oe),
  .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
  .extest_on(extest_on), .bsr_sel(bsr_sel)
);

// File: tb/jtag_tap_ctrl_tb.sv
module jtag_tap_ctrl_tb;
  localparam logic [3:0]  VER    = 4'h3;
  localparam logic [31:0] ID_EXP = {VER, 16'h6410, 11'h020, 1'b1};

  // model state numbering (bench-local)
  localparam int M_RST = 0, M_RTI = 1, M_SDR = 2, M_CDR = 3, M_HDR = 4, M_X1D = 5,
                 M_PDR = 6, M_X2D = 7, M_UDR = 8, M_SIR = 9, M_CIR = 10, M_HIR = 11,
                 M_X1I = 12, M_PIR = 13, M_X2I = 14, M_UIR = 15;

  logic tck = 1'b0;
  logic trst_n = 1'b1;
  logic tms = 1'b1, tdi = 1'b0, bsr_so = 1'b0;
  logic tdo, tdo_oe, dr_capture, dr_shift, dr_update, extest_on, bsr_sel;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  int          m_s  = M_RST;
  logic [4:0]  m_sh = 5'b00001;
  logic [4:0]  m_ir = 5'b00001;
  logic        m_byp = 1'b0;
  logic [31:0] m_id = ID_EXP;
  logic        m_tdo = 1'b0, m_oe = 1'b0;

  jtag_tap_ctrl #(.ID_VERSION(VER)) u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .dr_capture(dr_capture), .dr_shift(dr_shift),
    .dr_update(dr_update), .extest_on(extest_on), .bsr_sel(bsr_sel));

  always #4 tck = ~tck;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_next(int s, bit t);
    case (s)
      M_RST: return t ? M_RST : M_RTI;
      M_RTI: return t ? M_SDR : M_RTI;
      M_SDR: return t ? M_SIR : M_CDR;
      M_CDR, M_HDR: return t ? M_X1D : M_HDR;
      M_X1D: return t ? M_UDR : M_PDR;
      M_PDR: return t ? M_X2D : M_PDR;
      M_X2D: return t ? M_UDR : M_HDR;
      M_SIR: return t ? M_RST : M_CIR;
      M_CIR, M_HIR: return t ? M_X1I : M_HIR;
      M_X1I: return t ? M_UIR : M_PIR;
      M_PIR: return t ? M_X2I : M_PIR;
      M_X2I: return t ? M_UIR : M_HIR;
      default: return t ? M_SDR : M_RTI; // both update states
    endcase
  endfunction

  function automatic bit is_bsr(logic [4:0] op);
    return (op == 5'b00000) || (op == 5'b00010);
  endfunction

  task automatic compare_all();
    string tag;
    check("R8", 32'(tdo_oe), 32'(m_oe));
    if (m_oe) begin
      if (m_s == M_HIR)          tag = "R3";
      else if (m_ir == 5'b00001) tag = "R6";
      else if (is_bsr(m_ir))     tag = "R9";
      else                       tag = "R7";
      check(tag, 32'(tdo), 32'(m_tdo));
    end
    check("R5", 32'(extest_on), 32'(m_ir == 5'b00000));
    check("R5", 32'(bsr_sel), 32'(is_bsr(m_ir)));
    check("R1", 32'({dr_capture, dr_shift, dr_update}),
          32'({m_s == M_CDR, m_s == M_HDR, m_s == M_UDR}));
  endtask

  task automatic step(input bit t, input bit d, input bit b);
    tms = t; tdi = d; bsr_so = b;
    @(posedge tck);
    if (trst_n) begin
      case (m_s)
        M_CIR: m_sh = 5'b00001;
        M_HIR: m_sh = {d, m_sh[4:1]};
        M_CDR: begin m_byp = 1'b0; if (m_ir == 5'b00001) m_id = ID_EXP; end
        M_HDR: begin m_byp = d; if (m_ir == 5'b00001) m_id = {d, m_id[31:1]}; end
        default: ;
      endcase
      m_s = m_next(m_s, t);
    end
    @(negedge tck);
    if (trst_n) begin
      m_oe = (m_s == M_HIR) || (m_s == M_HDR);
      if (m_s == M_HIR) m_tdo = m_sh[0];
      else if (m_ir == 5'b00001) m_tdo = m_id[0];
      else if (is_bsr(m_ir)) m_tdo = b;
      else m_tdo = m_byp;
      if (m_s == M_UIR) m_ir = m_sh;
      if (m_s == M_RST) m_ir = 5'b00001;
    end
    #1;
    compare_all();
  endtask

  task automatic model_reset();
    m_s = M_RST; m_ir = 5'b00001; m_oe = 1'b0; m_tdo = 1'b0;
    m_sh = 5'b00001; m_byp = 1'b0; m_id = ID_EXP;
  endtask

  task automatic scan_ir(input logic [4:0] op, output logic [4:0] cap);
    step(1, 0, 0); step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      cap[i] = tdo;
      step(i == 4, op[i], 0);
    end
    step(1, 0, 0); step(0, 0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, input logic [31:0] bso,
                         output logic [31:0] dout);
    dout = '0;
    step(1, 0, 0); step(0, 0, 0); step(0, 0, bso[0]);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i], (i + 1 < n) ? bso[i + 1] : 1'b0);
    end
    step(1, 0, 0); step(0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [4:0]  c;
    logic [31:0] d;
    #1 trst_n = 1'b0;
    #1 check("R2", 32'({tdo_oe, extest_on}), 32'b0);
    step(1, 0, 0); step(1, 0, 0);
    trst_n = 1'b1;
    step(1, 0, 0);
    check("R10", 32'(bsr_sel), 32'b0);
    step(0, 0, 0);

    // identification word after reset
    scan_dr(32, 32'h0, 32'h0, d);
    check("R6", d, ID_EXP);

    // instruction capture pattern, load pass-through
    scan_ir(5'b11111, c);
    check("R3", 32'(c), 32'b00001);
    scan_dr(8, 32'hB5, 32'h0, d);
    check("R7", d, 32'h6A);

    // unlisted code behaves as pass-through
    scan_ir(5'b10110, c);
    check("R5", 32'({bsr_sel, extest_on}), 32'b00);
    scan_dr(4, 32'b1011, 32'hF, d);
    check("R5", d, 32'b0110);

    // sample/preload selects boundary, not external test
    scan_ir(5'b00010, c);
    check("R5", 32'({bsr_sel, extest_on}), 32'b10);
    scan_dr(6, 32'h0, 32'b101101, d);
    check("R9", d, 32'b101101);

    // external test only after Update-IR
    step(1, 0, 0); step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
    for (int i = 0; i < 5; i++) step(i == 4, 1'b0, 0);
    check("R4", 32'(extest_on), 32'b0);
    step(1, 0, 0);
    check("R4", 32'({extest_on, bsr_sel}), 32'b11);
    step(0, 0, 0);
    scan_dr(5, 32'h0, 32'b10011, d);
    check("R9", d, 32'b10011);

    // mode-select reset path
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    check("R10", 32'(extest_on), 32'b0);
    step(0, 0, 0);
    scan_dr(32, 32'h0, 32'h0, d);
    check("R10", d, ID_EXP);

    // asynchronous reset in the middle of a data shift
    scan_ir(5'b00000, c);
    step(1, 0, 0); step(0, 0, 0); step(0, 0, 1);
    check("R8", 32'(tdo_oe), 32'b1);
    trst_n = 1'b0;
    #1 check("R2", 32'({tdo_oe, extest_on, bsr_sel}), 32'b000);
    model_reset();
    step(0, 0, 0);
    trst_n = 1'b1;
    step(0, 0, 0);
    scan_dr(32, 32'h0, 32'h0, d);
    check("R2", d, ID_EXP);

    // output changes on the falling edge, not the rising one
    scan_ir(5'b11111, c);
    step(1, 0, 0); step(0, 0, 0); step(0, 1, 0);
    check("R7", 32'(tdo), 32'b0);
    @(posedge tck); #1;
    check("R8", 32'(tdo), 32'b0);
    @(negedge tck); #1;
    check("R8", 32'(tdo), 32'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule